// File: doc/BRIEF.md
# HDLC Controller Request Combiner

This block sits beside the data path of a bit-oriented serial link controller and decides when the host must be told about work. It holds the first control word, whose enable bits select, separately for each direction, whether the direction is served by interrupts or by a DMA engine. It folds the transmit and receive status flags from the data path into one interrupt line and two DMA request lines.

The transmit "data register available" flag arrives raw from the transmit FIFO. It is qualified here: it is forced low while the transmitter is held in reset or while clear-to-send status is set. Putting a direction into DMA mode silences that direction's interrupt sources, and the direction's request line then follows its data-ready flag. A read of the receive data register, whether by the CPU or by the DMA engine, takes the receive request down at the next clock in any mode. If data is still waiting, the request comes back one cycle later.

With the default `REG_OUT = 1`, a status input change reaches `irq`, `rx_dma_req` and `tx_dma_req` one clock edge after it is sampled. A control word write reaches them two edges after the write. The `irq` output is also the value the host sees as bit 7 of the first status register.

Top module: `hdlc_req_ctl`

## Requirements
- R1: During and right after reset, `irq`, `rx_dma_req`, `tx_dma_req` and `rx_discard` are 0, and every control enable is clear.
- R2: A write with `cr_wr` high loads `cr_wdata` at that edge. The fields are: bit 1 receive interrupt enable, bit 2 transmit interrupt enable, bit 3 receive DMA mode, bit 4 transmit DMA mode, bit 5 discard-frame. An enable change shows on `irq` two edges after the write edge.
- R3: `tx_space` is `tx_space_raw` forced low whenever `tx_reset` or `cts_status` is high.
- R4: The transmit side raises `irq` when transmit interrupt enable is 1, transmit DMA mode is 0, and `tx_underrun` or the qualified `tx_space` is 1.
- R5: The receive side raises `irq` when receive interrupt enable is 1, receive DMA mode is 0, and `st2_req`, `rx_avail` or `cts_status` is 1.
- R6: With DMA mode set for a direction, that direction's sources never raise `irq`. With DMA mode set for both directions, `irq` stays 0.
- R7: `rx_dma_req` follows `rx_avail` one edge later, in every mode.
- R8: An edge sampling `rx_data_rd` high drives `rx_dma_req` to 0 whatever the mode. At the next edge it returns to 1 if `rx_avail` is still 1 and `rx_data_rd` is low.
- R9: `tx_dma_req` follows the qualified `tx_space` one edge later, in every mode.
- R10: A control write with bit 5 set gives a single-cycle pulse on `rx_discard` after the write edge. A write with bit 5 clear gives no pulse.
- R11: While `rx_reset` is high, `rx_avail` is ignored: `rx_dma_req` is 0 and `rx_avail` adds no receive interrupt source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_wr | input | 1 | Control word write strobe |
| cr_wdata | input | CTL_W | Control word write data |
| tx_underrun | input | 1 | Transmit underrun status |
| tx_space_raw | input | 1 | Unqualified transmit data register available |
| rx_avail | input | 1 | Receive data available |
| st2_req | input | 1 | Second status register needs reading |
| cts_status | input | 1 | Clear-to-send status bit |
| tx_reset | input | 1 | Transmitter held in reset |
| rx_reset | input | 1 | Receiver held in reset |
| rx_data_rd | input | 1 | Read strobe of the receive data register |
| irq | output | 1 | Interrupt request (status bit 7) |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_space | output | 1 | Qualified transmit data register available |
| rx_discard | output | 1 | One-cycle discard-frame command to the receiver |

## Verification
The bench sets each DMA mode with its direction's interrupt enable on. A design that swapped the two masks, or ignored one of them, would raise `irq` while the DMA engine owns that direction. It also holds clear-to-send high while the transmitter has room. Clear-to-send counts only as a receive source, so a design that did not gate `tx_space` or treated clear-to-send as a transmit source would interrupt or request transmit DMA wrongly. The read strobe is pulsed while data stays available, in both receive modes. This catches a request that never drops, one that drops only in DMA mode, and one that stays latched low. Further tests target the discard pulse length, receiver-reset masking and the two-edge latency of a control write.

// File: rtl/hdlc_req_pkg.sv
package hdlc_req_pkg;
   // bit positions of the first control word; the request logic decodes them
   localparam int unsigned BIT_RX_IE   = 1;
   localparam int unsigned BIT_TX_IE   = 2;
   localparam int unsigned BIT_RX_DMA  = 3;
   localparam int unsigned BIT_TX_DMA  = 4;
   localparam int unsigned BIT_DISCARD = 5;
   localparam int unsigned CTL_MIN_W   = BIT_DISCARD + 1;

   typedef struct packed {
      logic rx_ie;
      logic tx_ie;
      logic rx_dma;
      logic tx_dma;
   } req_ctl_t;
endpackage

// File: rtl/hdlc_ctl_word.sv
module hdlc_ctl_word
   import hdlc_req_pkg::*;
#(
   parameter int unsigned CTL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CTL_W-1:0] wdata_i,
   output req_ctl_t         ctl_o,
   output logic             discard_o
);
   generate
      if (CTL_W < CTL_MIN_W) begin : g_bad_width
         $error("hdlc_ctl_word: CTL_W too narrow for the enable fields");
      end
   endgenerate

   logic [CTL_W-1:0] word_q;
   logic             discard_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q    <= '0;
         discard_q <= 1'b0;
      end else begin
         if (wr_i) word_q <= wdata_i;
         discard_q <= wr_i & wdata_i[BIT_DISCARD];
      end
   end

   always_comb begin
      ctl_o.rx_ie  = word_q[BIT_RX_IE];
      ctl_o.tx_ie  = word_q[BIT_TX_IE];
      ctl_o.rx_dma = word_q[BIT_RX_DMA];
      ctl_o.tx_dma = word_q[BIT_TX_DMA];
   end
   assign discard_o = discard_q;

   // R10: a discard pulse needs a write at the edge before it
   a_r10_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      discard_o |-> $past(wr_i));
   // R10: the pulse lasts one cycle unless another write follows
   a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (discard_o && !wr_i) |=> !discard_o);
endmodule

// File: rtl/hdlc_irq_merge.sv
module hdlc_irq_merge
   import hdlc_req_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  req_ctl_t ctl_i,
   input  logic     tx_underrun_i,
   input  logic     tx_space_i,
   input  logic     rx_avail_i,
   input  logic     st2_req_i,
   input  logic     cts_i,
   output logic     irq_o
);
   logic tx_src, rx_src, irq_d;

   always_comb begin
      tx_src = ctl_i.tx_ie & ~ctl_i.tx_dma & (tx_underrun_i | tx_space_i);
      rx_src = ctl_i.rx_ie & ~ctl_i.rx_dma & (st2_req_i | rx_avail_i | cts_i);
      irq_d  = tx_src | rx_src;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq_o = irq_q;

         // R6: both directions in DMA mode never interrupt
         a_r6_both_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_i.tx_dma && ctl_i.rx_dma) |=> !irq_o);
         // R6: with both enables off nothing interrupts
         a_r6_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_i.tx_ie && !ctl_i.rx_ie) |=> !irq_o);
         // R4: an enabled underrun outside DMA mode interrupts
         a_r4_underrun_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_i.tx_ie && !ctl_i.tx_dma && tx_underrun_i) |=> irq_o);
         // R5: clear-to-send is a receive source only
         a_r5_cts_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_i.rx_ie && !ctl_i.rx_dma && cts_i) |=> irq_o);
      end else begin : g_comb
         assign irq_o = irq_d;
      end
   endgenerate
endmodule

// File: rtl/hdlc_dma_req.sv
module hdlc_dma_req #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_avail_i,
   input  logic rx_rd_i,
   input  logic tx_space_i,
   output logic rx_req_o,
   output logic tx_req_o
);
   logic rx_d, tx_d;

   always_comb begin
      rx_d = rx_avail_i & ~rx_rd_i;
      tx_d = tx_space_i;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic rx_q, tx_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rx_q <= 1'b0;
               tx_q <= 1'b0;
            end else begin
               rx_q <= rx_d;
               tx_q <= tx_d;
            end
         end
         assign rx_req_o = rx_q;
         assign tx_req_o = tx_q;

         // R8: a read drops the receive request at the next edge
         a_r8_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
            rx_rd_i |=> !rx_req_o);
         // R7: no data, no receive request
         a_r7_no_data_no_req: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_avail_i |=> !rx_req_o);
         // R9: no room, no transmit request
         a_r9_no_space_no_req: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_space_i |=> !tx_req_o);
      end else begin : g_comb
         assign rx_req_o = rx_d;
         assign tx_req_o = tx_d;
      end
   endgenerate
endmodule

// File: rtl/hdlc_req_ctl.sv
module hdlc_req_ctl
   import hdlc_req_pkg::*;
#(
   parameter int unsigned CTL_W   = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cr_wr,
   input  logic [CTL_W-1:0] cr_wdata,
   input  logic             tx_underrun,
   input  logic             tx_space_raw,
   input  logic             rx_avail,
   input  logic             st2_req,
   input  logic             cts_status,
   input  logic             tx_reset,
   input  logic             rx_reset,
   input  logic             rx_data_rd,
   output logic             irq,
   output logic             rx_dma_req,
   output logic             tx_dma_req,
   output logic             tx_space,
   output logic             rx_discard
);
   req_ctl_t ctl;
   logic     rx_avail_q;

   // R3: transmit room is hidden by transmitter reset and by clear-to-send
   assign tx_space   = tx_space_raw & ~tx_reset & ~cts_status;
   // R11: a receiver in reset offers no data
   assign rx_avail_q = rx_avail & ~rx_reset;

   hdlc_ctl_word #(.CTL_W(CTL_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (cr_wr),
      .wdata_i   (cr_wdata),
      .ctl_o     (ctl),
      .discard_o (rx_discard)
   );

   hdlc_irq_merge #(.REG_OUT(REG_OUT)) u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_i         (ctl),
      .tx_underrun_i (tx_underrun),
      .tx_space_i    (tx_space),
      .rx_avail_i    (rx_avail_q),
      .st2_req_i     (st2_req),
      .cts_i         (cts_status),
      .irq_o         (irq)
   );

   hdlc_dma_req #(.REG_OUT(REG_OUT)) u_dma (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_avail_i (rx_avail_q),
      .rx_rd_i    (rx_data_rd),
      .tx_space_i (tx_space),
      .rx_req_o   (rx_dma_req),
      .tx_req_o   (tx_dma_req)
   );

   generate
      if (REG_OUT) begin : g_chk
         // R3: clear-to-send or transmitter reset blocks the transmit request
         a_r3_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_reset || cts_status) |=> !tx_dma_req);
         // R11: receiver reset blocks the receive request
         a_r11_rx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            rx_reset |=> !rx_dma_req);
      end
   endgenerate
endmodule

// File: tb/hdlc_req_ctl_tb.sv
module hdlc_req_ctl_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cr_wr = 1'b0;
   logic [7:0] cr_wdata = '0;
   logic       tx_underrun = 0, tx_space_raw = 0, rx_avail = 0, st2_req = 0;
   logic       cts_status = 0, tx_reset = 0, rx_reset = 0, rx_data_rd = 0;
   logic       irq, rx_dma_req, tx_dma_req, tx_space, rx_discard;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_req_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .cr_wr(cr_wr), .cr_wdata(cr_wdata),
      .tx_underrun(tx_underrun), .tx_space_raw(tx_space_raw), .rx_avail(rx_avail),
      .st2_req(st2_req), .cts_status(cts_status), .tx_reset(tx_reset),
      .rx_reset(rx_reset), .rx_data_rd(rx_data_rd), .irq(irq),
      .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .tx_space(tx_space),
      .rx_discard(rx_discard)
   );

   // {control word, underrun, raw room, rx avail, st2, cts, tx reset, exp irq, exp rx req, exp tx req}
   localparam int NVEC = 13;
   localparam logic [16:0] VEC [NVEC] = '{
      {8'h00, 6'b000000, 3'b000},
      {8'h04, 6'b010000, 3'b101},  // R4 room interrupts
      {8'h04, 6'b010010, 3'b000},  // R3 cts hides room
      {8'h04, 6'b100000, 3'b100},  // R4 underrun
      {8'h14, 6'b010000, 3'b001},  // R6 tx dma masks
      {8'h02, 6'b001000, 3'b110},  // R5 rx avail
      {8'h02, 6'b000100, 3'b100},  // R5 st2
      {8'h02, 6'b000010, 3'b100},  // R5 cts
      {8'h0A, 6'b001000, 3'b010},  // R6 rx dma masks, R7 request
      {8'h04, 6'b010001, 3'b000},  // R3 tx reset hides room
      {8'h00, 6'b011000, 3'b011},  // R7 R9 requests need no enable
      {8'h1E, 6'b101000, 3'b010},  // R6 both dma
      {8'h06, 6'b010100, 3'b101}   // R4 R5 mixed
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      tick();
      // R1 reset state
      check("R1 irq", irq, 1'b0);
      check("R1 rx_dma_req", rx_dma_req, 1'b0);
      check("R1 tx_dma_req", tx_dma_req, 1'b0);
      check("R1 rx_discard", rx_discard, 1'b0);
      rst_n = 1'b1;
      // R1 enables clear: underrun alone must not interrupt
      tx_underrun = 1'b1;
      tick(); tick();
      check("R1 enables clear", irq, 1'b0);
      tx_underrun = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         cr_wr = 1'b1; cr_wdata = VEC[i][16:9];
         {tx_underrun, tx_space_raw, rx_avail, st2_req, cts_status, tx_reset} = VEC[i][8:3];
         tick();
         cr_wr = 1'b0;
         tick();
         check($sformatf("R4/R5/R6 irq vec%0d", i), irq, VEC[i][2]);
         check($sformatf("R7 rx_dma_req vec%0d", i), rx_dma_req, VEC[i][1]);
         check($sformatf("R9 tx_dma_req vec%0d", i), tx_dma_req, VEC[i][0]);
         check($sformatf("R3 tx_space vec%0d", i), tx_space,
               tx_space_raw & ~tx_reset & ~cts_status);
      end
      {tx_underrun, tx_space_raw, rx_avail, st2_req, cts_status, tx_reset} = '0;

      // R2 latency: enable write shows on irq two edges later
      tx_space_raw = 1'b1;
      cr_wr = 1'b1; cr_wdata = 8'h00; tick(); cr_wr = 1'b0; tick();
      cr_wr = 1'b1; cr_wdata = 8'h04; tick(); cr_wr = 1'b0;
      check("R2 one edge after write", irq, 1'b0);
      tick();
      check("R2 two edges after write", irq, 1'b1);
      tx_space_raw = 1'b0;

      // R8 read drops request, then it returns; normal mode
      cr_wr = 1'b1; cr_wdata = 8'h00; tick(); cr_wr = 1'b0;
      rx_avail = 1'b1; tick();
      check("R8 request before read", rx_dma_req, 1'b1);
      rx_data_rd = 1'b1; tick(); rx_data_rd = 1'b0;
      check("R8 dropped by read", rx_dma_req, 1'b0);
      tick();
      check("R8 returns after read", rx_dma_req, 1'b1);
      // R8 in receive DMA mode
      cr_wr = 1'b1; cr_wdata = 8'h08; tick(); cr_wr = 1'b0;
      rx_data_rd = 1'b1; tick(); rx_data_rd = 1'b0;
      check("R8 dropped in dma mode", rx_dma_req, 1'b1 ^ 1'b1);
      tick();
      check("R8 returns in dma mode", rx_dma_req, 1'b1);

      // R11 receiver reset hides data from request and interrupt
      cr_wr = 1'b1; cr_wdata = 8'h02; tick(); cr_wr = 1'b0;
      rx_reset = 1'b1; tick(); tick();
      check("R11 rx_dma_req", rx_dma_req, 1'b0);
      check("R11 irq", irq, 1'b0);
      rx_reset = 1'b0; tick();
      check("R11 released", rx_dma_req, 1'b1);
      rx_avail = 1'b0;

      // R10 discard pulse
      cr_wr = 1'b1; cr_wdata = 8'h20; tick(); cr_wr = 1'b0;
      check("R10 pulse", rx_discard, 1'b1);
      tick();
      check("R10 single cycle", rx_discard, 1'b0);
      cr_wr = 1'b1; cr_wdata = 8'h1E; tick(); cr_wr = 1'b0;
      check("R10 no pulse without bit5", rx_discard, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule